// File: doc/BRIEF.md
# Eight-Pin Bidirectional GPIO Port

This block is an eight-pin general-purpose port that sits on a simple synchronous register bus. Software selects, pin by pin, whether the pad drives or listens, sets the value driven on output pins, and reads back the live level on every pad. The pad side has a value bus, an output-enable bus and a pad-input bus, with each pad input passed through a synchroniser before the bus can see it.

Two power-saving inputs act on the port in different ways. Hardware standby wipes the configuration, releases every pad and locks out bus writes. Software standby leaves all settings as they are and keeps output pins driven, and bus writes are held off so the frozen state cannot change. A system reset has the same clearing effect as hardware standby.

Three offsets are in use. Offset 0 holds the pin directions and can only be written. Offset 1 holds the output values and can be written and read. Offset 2 returns the pad levels and can only be read. Offset 3 is unmapped.

Top module: `gpio_port8`

## Requirements
- R1: After the active-low reset `rst_n`, the direction bits and output values are all 0, `pad_oe` and `pad_out` are 0x00, and `bus_rdata` is 0x00.
- R2: A write to offset 0 sets the direction bits. A bit value of 1 makes that pin an output and a bit value of 0 makes it an input. The new value takes effect after the clock edge that samples the write.
- R3: Offset 1 can be written and read whatever the direction bits are set to. A read returns the last value written.
- R4: A read of offset 0 (direction) or offset 3 (unmapped) returns 0xFF and changes no state.
- R5: When hardware standby is low, `pad_oe` equals the direction bits bit for bit and `pad_out` equals the output register.
- R6: A write to offset 2 has no effect on the direction bits, the output register or the pads.
- R7: A read of offset 2 returns the pad levels after a two-flop synchroniser. The two reads issued in the two cycles that directly follow a pad change return the old level. The third read returns the new level. The levels of pins driven as outputs are read from the pads, not from the output register.
- R8: Reads are registered. `bus_rdata` holds the result in the cycle after `bus_rd` and keeps it until the next read. If a read and a write to offset 1 fall in the same cycle, the read returns the value from before the write.
- R9: While `sw_stby` is high (and `hw_stby` is low), the direction bits and output register keep their values, bus writes are ignored, and output pins keep driving.
- R10: While `hw_stby` is high, `pad_oe` is 0x00 in the same cycle, both registers clear to 0x00 at the next clock edge, and bus writes are ignored. When standby ends, the cleared values remain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and port clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| hw_stby | input | 1 | Hardware standby: clears registers and releases the pads |
| sw_stby | input | 1 | Software standby: freezes registers and keeps the pads driven |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_out | output | 8 | Value driven to the pads |
| pad_oe | output | 8 | Per-pad output enable |
| pad_in | input | 8 | Pad levels, asynchronous to `clk` |

## Verification
A read and a write to the output register can land in the same cycle. The bench provokes this with a single bus cycle that raises both strobes at offset 1. The scoreboard expects the value from before the write for that read, and the new value for the read that follows. A standby request can also meet a bus write. The bench issues writes while each standby input is high, then checks the pads at once and reads back the output register after standby ends, so any write that slipped through shows up.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DIR  = 2'd0,
    SEL_OUT  = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
    return reg_sel_e'(a);
  endfunction

  // Bus writes are accepted only when neither standby input is active.
  function automatic logic write_allowed(input logic hw, input logic sw);
    return !(hw || sw);
  endfunction
endpackage

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  odr_q,
  output logic              wr_dir_evt,
  output logic              wr_out_evt
);
  logic wr_ok;

  assign wr_ok      = wr && write_allowed(hw_stby, sw_stby);
  assign wr_dir_evt = wr_ok && (decode_sel(addr) == SEL_DIR);
  assign wr_out_evt = wr_ok && (decode_sel(addr) == SEL_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      odr_q <= '0;
    end else if (hw_stby) begin
      dir_q <= '0;
      odr_q <= '0;
    end else begin
      if (wr_dir_evt) dir_q <= wdata;
      if (wr_out_evt) odr_q <= wdata;
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_rd_port.sv
module gpio_rd_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  odr_q,
  input  logic [WIDTH-1:0]  pin_q,
  output logic [WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0] rd_mux;

  always_comb begin
    unique case (decode_sel(addr))
      SEL_OUT: rd_mux = odr_q;
      SEL_PIN: rd_mux = pin_q;
      default: rd_mux = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_port8.sv
module gpio_port8
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  input  logic [WIDTH-1:0]  pad_in
);
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] odr_q;
  logic [WIDTH-1:0] pin_q;
  logic             wr_dir_evt;
  logic             wr_out_evt;

  gpio_ctrl_regs #(.WIDTH(WIDTH)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_stby    (hw_stby),
    .sw_stby    (sw_stby),
    .wr         (bus_wr),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .dir_q      (dir_q),
    .odr_q      (odr_q),
    .wr_dir_evt (wr_dir_evt),
    .wr_out_evt (wr_out_evt)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_q)
  );

  gpio_rd_port #(.WIDTH(WIDTH)) u_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .rd    (bus_rd),
    .addr  (bus_addr),
    .odr_q (odr_q),
    .pin_q (pin_q),
    .rdata (bus_rdata)
  );

  assign pad_oe  = hw_stby ? '0 : dir_q;
  assign pad_out = odr_q;
endmodule

// File: rtl/gpio_port8_checker.sv
module gpio_port8_checker #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hw_stby,
  input logic             sw_stby,
  input logic [1:0]       bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [WIDTH-1:0] bus_rdata,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] odr_q,
  input logic [WIDTH-1:0] pin_q
);
  p_oe_follows_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_stby |-> (pad_oe == dir_q && pad_out == odr_q));

  p_hw_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |-> (pad_oe == '0));

  p_hw_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (dir_q == '0 && odr_q == '0));

  p_sw_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !hw_stby) |=> ($stable(dir_q) && $stable(odr_q)));

  p_pin_wr_void_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2 && !hw_stby) |=> ($stable(dir_q) && $stable(odr_q)));

  p_rd_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == 2'd0 || bus_addr == 2'd3)) |=> (bus_rdata == '1));

  p_rd_old_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd1) |=> (bus_rdata == $past(odr_q)));

  p_rd_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd2) |=> (bus_rdata == $past(pin_q)));

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind gpio_port8 gpio_port8_checker #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hw_stby   (hw_stby),
  .sw_stby   (sw_stby),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .dir_q     (dir_q),
  .odr_q     (odr_q),
  .pin_q     (pin_q)
);

// File: tb/gpio_port8_test.sv
module gpio_port8_test;
  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_stby = 1'b0;
  logic       sw_stby = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;
  logic [7:0] pad_in = '0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  exp_item_t sb_q[$];

  always #2.5 clk = ~clk;

  gpio_port8 uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_stby   (hw_stby),
    .sw_stby   (sw_stby),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_in    (pad_in)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One bus cycle, starting and ending just after a falling edge.
  task automatic bus_cycle(input logic wr, input logic rd, input logic [1:0] a,
                           input logic [7:0] d, input logic [7:0] exp, input string tag);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    if (rd) sb_q.push_back('{exp: exp, tag: tag});
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    bus_cycle(1'b1, 1'b0, a, d, 8'h00, "");
  endtask

  task automatic rd_reg(input logic [1:0] a, input logic [7:0] exp, input string tag);
    bus_cycle(1'b0, 1'b1, a, 8'h00, exp, tag);
  endtask

  // Monitor: a read seen at a rising edge is compared at the next falling edge.
  initial begin
    forever begin
      logic rd_seen;
      @(posedge clk);
      rd_seen = bus_rd;
      @(negedge clk);
      if (rd_seen) begin
        if (sb_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL scoreboard: read with no expected item");
        end else begin
          exp_item_t it;
          it = sb_q.pop_front();
          check(it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pad_oe reset", pad_oe, 8'h00);
    check("R1 pad_out reset", pad_out, 8'h00);
    check("R1 rdata reset", bus_rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 output register usable while all pins are inputs
    wr_reg(2'd1, 8'h3C);
    check("R3 oe stays 0 with dir 0", pad_oe, 8'h00);
    rd_reg(2'd1, 8'h3C, "R3 read out reg with dir 0");
    // R2 / R5 direction
    wr_reg(2'd0, 8'hA5);
    check("R2 R5 pad_oe after dir write", pad_oe, 8'hA5);
    check("R5 pad_out follows out reg", pad_out, 8'h3C);
    // R4 direction and unmapped reads
    rd_reg(2'd0, 8'hFF, "R4 dir read");
    rd_reg(2'd3, 8'hFF, "R4 unmapped read");
    check("R4 dir unchanged after read", pad_oe, 8'hA5);
    rd_reg(2'd1, 8'h3C, "R4 out reg unchanged after reads");

    // R6 write to pin register ignored
    wr_reg(2'd2, 8'h00);
    check("R6 oe unchanged", pad_oe, 8'hA5);
    check("R6 pad_out unchanged", pad_out, 8'h3C);
    rd_reg(2'd1, 8'h3C, "R6 out reg unchanged");

    // R7 synchroniser latency, pads differ from out reg
    pad_in = 8'h5A;
    rd_reg(2'd2, 8'h00, "R7 first read after change old");
    rd_reg(2'd2, 8'h00, "R7 second read after change old");
    rd_reg(2'd2, 8'h5A, "R7 third read new level");
    pad_in = 8'hC3;
    @(negedge clk);
    @(negedge clk);
    rd_reg(2'd2, 8'hC3, "R7 read after settle");

    // R8 read and write in the same cycle
    bus_cycle(1'b1, 1'b1, 2'd1, 8'h0F, 8'h3C, "R8 same-cycle read returns old");
    rd_reg(2'd1, 8'h0F, "R8 next read returns new");
    @(negedge clk);
    check("R8 rdata holds without read", bus_rdata, 8'h0F);

    // R9 software standby
    sw_stby = 1'b1;
    wr_reg(2'd0, 8'hFF);
    wr_reg(2'd1, 8'hFF);
    check("R9 oe kept in sw standby", pad_oe, 8'hA5);
    check("R9 pad_out kept in sw standby", pad_out, 8'h0F);
    sw_stby = 1'b0;
    rd_reg(2'd1, 8'h0F, "R9 out reg kept after sw standby");

    // R10 hardware standby
    hw_stby = 1'b1;
    #1;
    check("R10 oe released at once", pad_oe, 8'h00);
    @(negedge clk);
    check("R10 pad_out cleared", pad_out, 8'h00);
    wr_reg(2'd0, 8'hFF);
    wr_reg(2'd1, 8'h77);
    check("R10 write ignored in hw standby", pad_out, 8'h00);
    hw_stby = 1'b0;
    #1;
    check("R10 oe stays 0 after hw standby", pad_oe, 8'h00);
    @(negedge clk);
    rd_reg(2'd1, 8'h00, "R10 out reg cleared");
    rd_reg(2'd0, 8'hFF, "R4 dir read after standby");

    repeat (2) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule